// File: doc/BRIEF.md
# DDS Frequency Sweep and Phase Accumulator Controller

This block is the numeric core of a direct digital synthesizer. A 32-bit control word picks one of five operating modes. Two 48-bit tuning words (F1, F2), a ramp step, a ramp rate, two phase-offset words and an amplitude multiplier complete its configuration. A frequency accumulator (the ramp accumulator) produces the current tuning word in the ramping modes. That word, or a tuning word chosen directly, is added every clock into a 48-bit phase accumulator. The top bits of the phase accumulator, plus an optional phase offset, leave the block as the phase word for a downstream sine lookup.

All configuration inputs are applied together on a one-cycle update strobe. Until that strobe arrives they have no effect. Three control bits clear or stop the accumulators. One bit gives a single clear pulse to the ramp accumulator and then resets itself. A second bit holds both accumulators at zero for as long as it stays set. A third bit freezes the core until the next reset. A triangle bit turns the ramped-FSK mode into a continuous up/down sweep between F1 and F2. The amplitude path puts out a gating factor taken from full scale, from a programmed multiplier, or from an internal ramp. A flag output reports whether the inverse-sinc stage is bypassed.

Top module: `dds_sweep_ctrl`

## Requirements
- R1: The control word, tuning words, step, rate, offsets and amplitude multiplier are loaded only in a cycle where `update_i` is 1. Input changes without the strobe leave the outputs unaffected.
- R2: The mode is control bits [11:9]: 0 single tone, 1 FSK, 2 ramped FSK, 3 chirp, 4 BPSK. Codes 5, 6 and 7 behave as single tone, in which the phase accumulator advances by F1 every clock.
- R3: In FSK mode the phase increment is F2 while `data_i` is 1 and F1 while it is 0.
- R4: In BPSK mode the phase increment is F1. The phase output has offset word 2 added while `data_i` is 1 and offset word 1 added while it is 0. No offset is added in any other mode.
- R5: In chirp mode the increment is F1 plus the ramp accumulator. The ramp accumulator grows by the step once every (rate+1) clocks and wraps.
- R6: In ramped FSK mode with the triangle bit (bit 13) clear, the increment is the ramp accumulator. It moves by one step per rate tick toward F2 while `data_i` is 1 and toward F1 while it is 0, and is clamped to that target rather than passing it.
- R7: With bit 13 set in ramped FSK mode, the ramp accumulator rises to F2, then falls to F1, and repeats. It reverses on reaching or passing an endpoint and is clamped to it. In every other mode bit 13 has no effect.
- R8: Writing bit 15 as 1 zeroes the ramp accumulator exactly once, one clock after the strobe, in any mode. The bit does not stay set, and the loaded tuning and step words are kept.
- R9: While control bit 14 is 1, both accumulators are held at 0. Once it is cleared, the phase starts again from 0.
- R10: Writing bit 27 as 1 freezes both accumulators and the amplitude ramp until `rst_ni` is asserted. Later updates do not release them.
- R11: The amplitude factor is full scale when bit 5 is 0. It is the multiplier register when bits 5 and 4 are 1 and 0. When both are 1 it is an internal ramp that moves by 1 per clock, up while `data_i` is 1 and down while it is 0, saturating at 0 and full scale.
- R12: `sinc_bypass_o` is control bit 6 of the applied control word.
- R13: After reset the phase is 0, the control word has only bit 5 set and the multiplier is 0, so `amp_o` is 0 and `sinc_bypass_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| update_i | input | 1 | One-cycle strobe that applies all configuration inputs |
| ctrl_word_i | input | 32 | Control word |
| f1_word_i | input | PHASE_W | Tuning word F1 |
| f2_word_i | input | PHASE_W | Tuning word F2 |
| step_word_i | input | PHASE_W | Ramp accumulator step |
| ramp_rate_i | input | RATE_W | Clocks between ramp steps, minus one |
| phase_off1_i | input | OUT_W | BPSK phase offset used while data is 0 |
| phase_off2_i | input | OUT_W | BPSK phase offset used while data is 1 |
| amp_mult_i | input | AMP_W | Programmed amplitude multiplier |
| data_i | input | 1 | FSK/BPSK/keying data pin |
| phase_o | output | OUT_W | Truncated phase plus offset |
| amp_o | output | AMP_W | Amplitude gating factor |
| sinc_bypass_o | output | 1 | Inverse-sinc bypass flag |

## Verification
The phase accumulator is the main function. Setting a tuning word of 2^32 makes each clock's change of `phase_o` read out the current increment directly. That lets the bench recover the ramp accumulator trajectory cycle by cycle. A ramp step that does not divide the F1–F2 span separates correct endpoint clamping from overshoot. A triangle run with a low F1 shows both reversals and their timing. The same triangle bit used in chirp mode shows that the mode gate works. A running chirp followed by a bit-15 write shows a single zeroing and no repeat. A settled ramped-FSK run shows that the clear acts outside chirp and that the step is kept. Tone, FSK, BPSK and the unused mode codes are each run against two different F1/F2 values, so a wrong selection changes the phase slope.

// File: rtl/dds_sweep_pkg.sv
package dds_sweep_pkg;
  typedef enum logic [2:0] {
    MODE_TONE  = 3'd0,
    MODE_FSK   = 3'd1,
    MODE_RFSK  = 3'd2,
    MODE_CHIRP = 3'd3,
    MODE_BPSK  = 3'd4
  } mode_e;

  localparam int CTRL_W      = 32;
  localparam int CB_HALT     = 27;
  localparam int CB_CLR_RAMP = 15;
  localparam int CB_CLR_ALL  = 14;
  localparam int CB_TRI      = 13;
  localparam int CB_MODE_LSB = 9;
  localparam int CB_SINC_BYP = 6;
  localparam int CB_KEY_EN   = 5;
  localparam int CB_KEY_INT  = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST = 32'h0000_0020;

  function automatic mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return MODE_FSK;
      3'd2:    return MODE_RFSK;
      3'd3:    return MODE_CHIRP;
      3'd4:    return MODE_BPSK;
      default: return MODE_TONE;
    endcase
  endfunction
endpackage

// File: rtl/dds_ramp_acc.sv
module dds_ramp_acc
  import dds_sweep_pkg::*;
#(
  parameter int W      = 48,
  parameter int RATE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  mode_e             mode_i,
  input  logic              tri_i,
  input  logic              data_i,
  input  logic [W-1:0]      f1_i,
  input  logic [W-1:0]      f2_i,
  input  logic [W-1:0]      step_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [W-1:0]      acc_o
);
  logic [W-1:0]      acc_q, acc_d, target;
  logic              up_q, up_d, tick;
  logic [RATE_W-1:0] cnt_q;
  logic [W:0]        sum_x, dif_x;

  assign tick   = (cnt_q == rate_i);
  assign sum_x  = {1'b0, acc_q} + {1'b0, step_i};
  assign dif_x  = {1'b0, acc_q} - {1'b0, step_i};
  assign target = data_i ? f2_i : f1_i;

  always_comb begin
    acc_d = acc_q;
    up_d  = up_q;
    if (tick) begin
      case (mode_i)
        MODE_CHIRP: acc_d = sum_x[W-1:0];
        MODE_RFSK: begin
          if (tri_i) begin
            if (up_q) begin
              if (sum_x >= {1'b0, f2_i}) begin
                acc_d = f2_i;
                up_d  = 1'b0;
              end else acc_d = sum_x[W-1:0];
            end else begin
              if (dif_x[W] || dif_x[W-1:0] <= f1_i) begin
                acc_d = f1_i;
                up_d  = 1'b1;
              end else acc_d = dif_x[W-1:0];
            end
          end else if (acc_q < target) begin
            acc_d = (sum_x >= {1'b0, target}) ? target : sum_x[W-1:0];
          end else if (acc_q > target) begin
            acc_d = (dif_x[W] || dif_x[W-1:0] <= target) ? target : dif_x[W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      up_q  <= 1'b1;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick ? '0 : cnt_q + RATE_W'(1);
      if (clr_i) begin
        acc_q <= '0;
        up_q  <= 1'b1;
      end else begin
        acc_q <= acc_d;
        up_q  <= up_d;
      end
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int W     = 48,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [W-1:0]     freq_i,
  input  logic [OUT_W-1:0] offset_i,
  output logic [W-1:0]     acc_o,
  output logic [OUT_W-1:0] phase_o
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (run_i) acc_q <= clr_i ? '0 : acc_q + freq_i;
  end

  assign acc_o   = acc_q;
  assign phase_o = acc_q[W-1 -: OUT_W] + offset_i;
endmodule

// File: rtl/dds_amp_key.sv
module dds_amp_key #(
  parameter int AMP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             int_i,
  input  logic             up_i,
  input  logic [AMP_W-1:0] mult_i,
  output logic [AMP_W-1:0] ramp_o,
  output logic [AMP_W-1:0] amp_o
);
  logic [AMP_W-1:0] ramp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ramp_q <= '0;
    else if (run_i && en_i && int_i) begin
      if (up_i && ramp_q != '1)       ramp_q <= ramp_q + AMP_W'(1);
      else if (!up_i && ramp_q != '0) ramp_q <= ramp_q - AMP_W'(1);
    end
  end

  assign ramp_o = ramp_q;
  assign amp_o  = !en_i ? '1 : (int_i ? ramp_q : mult_i);
endmodule

// File: rtl/dds_sweep_ctrl.sv
module dds_sweep_ctrl
  import dds_sweep_pkg::*;
#(
  parameter int PHASE_W = 48,
  parameter int OUT_W   = 16,
  parameter int AMP_W   = 12,
  parameter int RATE_W  = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               update_i,
  input  logic [31:0]        ctrl_word_i,
  input  logic [PHASE_W-1:0] f1_word_i,
  input  logic [PHASE_W-1:0] f2_word_i,
  input  logic [PHASE_W-1:0] step_word_i,
  input  logic [RATE_W-1:0]  ramp_rate_i,
  input  logic [OUT_W-1:0]   phase_off1_i,
  input  logic [OUT_W-1:0]   phase_off2_i,
  input  logic [AMP_W-1:0]   amp_mult_i,
  input  logic               data_i,
  output logic [OUT_W-1:0]   phase_o,
  output logic [AMP_W-1:0]   amp_o,
  output logic               sinc_bypass_o
);
  localparam logic [CTRL_W-1:0] SELF_CLR_MASK = ~(CTRL_W'(1) << CB_CLR_RAMP);

  logic [CTRL_W-1:0]  ctrl_q;
  logic [PHASE_W-1:0] f1_q, f2_q, step_q;
  logic [RATE_W-1:0]  rate_q;
  logic [OUT_W-1:0]   off1_q, off2_q, offset;
  logic [AMP_W-1:0]   amp_q, amp_ramp_q;
  logic               clr1_q, halt_q, run;
  mode_e              mode;
  logic [PHASE_W-1:0] acc1_q, acc2_q, freq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      f1_q   <= '0;
      f2_q   <= '0;
      step_q <= '0;
      rate_q <= '0;
      off1_q <= '0;
      off2_q <= '0;
      amp_q  <= '0;
      clr1_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      clr1_q <= update_i & ctrl_word_i[CB_CLR_RAMP];
      halt_q <= halt_q | (update_i & ctrl_word_i[CB_HALT]);
      if (update_i) begin
        ctrl_q <= ctrl_word_i & SELF_CLR_MASK;
        f1_q   <= f1_word_i;
        f2_q   <= f2_word_i;
        step_q <= step_word_i;
        rate_q <= ramp_rate_i;
        off1_q <= phase_off1_i;
        off2_q <= phase_off2_i;
        amp_q  <= amp_mult_i;
      end
    end
  end

  assign run  = !halt_q;
  assign mode = decode_mode(ctrl_q[CB_MODE_LSB +: 3]);

  always_comb begin
    case (mode)
      MODE_FSK:   freq = data_i ? f2_q : f1_q;
      MODE_RFSK:  freq = acc1_q;
      MODE_CHIRP: freq = f1_q + acc1_q;
      default:    freq = f1_q;
    endcase
  end

  assign offset = (mode == MODE_BPSK) ? (data_i ? off2_q : off1_q) : '0;

  dds_ramp_acc #(.W(PHASE_W), .RATE_W(RATE_W)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (ctrl_q[CB_CLR_ALL] | clr1_q),
    .mode_i (mode),
    .tri_i  (ctrl_q[CB_TRI]),
    .data_i (data_i),
    .f1_i   (f1_q),
    .f2_i   (f2_q),
    .step_i (step_q),
    .rate_i (rate_q),
    .acc_o  (acc1_q)
  );

  dds_phase_acc #(.W(PHASE_W), .OUT_W(OUT_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .clr_i    (ctrl_q[CB_CLR_ALL]),
    .freq_i   (freq),
    .offset_i (offset),
    .acc_o    (acc2_q),
    .phase_o  (phase_o)
  );

  dds_amp_key #(.AMP_W(AMP_W)) u_amp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .en_i   (ctrl_q[CB_KEY_EN]),
    .int_i  (ctrl_q[CB_KEY_INT]),
    .up_i   (data_i),
    .mult_i (amp_q),
    .ramp_o (amp_ramp_q),
    .amp_o  (amp_o)
  );

  assign sinc_bypass_o = ctrl_q[CB_SINC_BYP];
endmodule

// File: rtl/dds_sweep_chk.sv
module dds_sweep_chk #(
  parameter int W     = 48,
  parameter int AMP_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             update_i,
  input logic [31:0]      ctrl_q,
  input logic             clr1_q,
  input logic             halt_q,
  input logic [W-1:0]     acc1_q,
  input logic [W-1:0]     acc2_q,
  input logic [AMP_W-1:0] amp_ramp_q
);
  // R1
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(ctrl_q));

  // R8
  ramp_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr1_q && !halt_q) |=> acc1_q == '0);

  // R9
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[14] && !halt_q) |=> (acc1_q == '0 && acc2_q == '0));

  // R10
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |=> ($stable(acc2_q) && $stable(acc1_q) && $stable(amp_ramp_q)));

  // R11
  amp_slew_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (amp_ramp_q == $past(amp_ramp_q) ||
              amp_ramp_q == $past(amp_ramp_q) + AMP_W'(1) ||
              amp_ramp_q == $past(amp_ramp_q) - AMP_W'(1)));
endmodule

bind dds_sweep_ctrl dds_sweep_chk #(.W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .update_i   (update_i),
  .ctrl_q     (ctrl_q),
  .clr1_q     (clr1_q),
  .halt_q     (halt_q),
  .acc1_q     (acc1_q),
  .acc2_q     (acc2_q),
  .amp_ramp_q (amp_ramp_q)
);

// File: tb/dds_sweep_ctrl_bench.sv
module dds_sweep_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] ONE = 48'h1_0000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        update_i = 1'b0;
  logic [31:0] ctrl_word_i = '0;
  logic [47:0] f1_word_i = '0, f2_word_i = '0, step_word_i = '0;
  logic [19:0] ramp_rate_i = '0;
  logic [15:0] phase_off1_i = '0, phase_off2_i = '0;
  logic [11:0] amp_mult_i = '0;
  logic        data_i = 1'b0;
  logic [15:0] phase_o;
  logic [11:0] amp_o;
  logic        sinc_bypass_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] prev_ph;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dds_sweep_ctrl u_dds_sweep_ctrl (
    .clk_i, .rst_ni, .update_i, .ctrl_word_i, .f1_word_i, .f2_word_i,
    .step_word_i, .ramp_rate_i, .phase_off1_i, .phase_off2_i, .amp_mult_i,
    .data_i, .phase_o, .amp_o, .sinc_bypass_o
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; update_i = 1'b0; ctrl_word_i = '0; data_i = 1'b0;
    f1_word_i = '0; f2_word_i = '0; step_word_i = '0; ramp_rate_i = '0;
    phase_off1_i = '0; phase_off2_i = '0; amp_mult_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // strobe at one negedge, return at the next one
  task automatic load(input logic [31:0] c);
    ctrl_word_i = c;
    update_i = 1'b1;
    @(negedge clk_i);
    update_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic mark();
    prev_ph = phase_o;
  endtask

  task automatic step_delta(input string req, input int exp);
    logic [15:0] d;
    @(negedge clk_i);
    d = phase_o - prev_ph;
    prev_ph = phase_o;
    chk(req, 64'(d), 64'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R13 phase", 64'(phase_o), 0);
    chk("R13 amp off", 64'(amp_o), 0);
    chk("R13 sinc", 64'(sinc_bypass_o), 0);
  endtask

  task automatic t_tone_update();
    do_reset();
    f1_word_i = ONE; f2_word_i = 7 * ONE; data_i = 1'b1;
    load(32'h0);
    wait_n(4);
    chk("R2 tone slope", 64'(phase_o), 4);
    f1_word_i = 5 * ONE; ctrl_word_i = 32'h200;
    wait_n(1);
    chk("R1 no strobe", 64'(phase_o), 5);
    load(32'h0);
    wait_n(1);
    chk("R1 after strobe", 64'(phase_o), 11);
    do_reset();
    f1_word_i = ONE; f2_word_i = 7 * ONE; data_i = 1'b1;
    load(32'hC00);
    wait_n(4);
    chk("R2 code 6 as tone", 64'(phase_o), 4);
    load(32'hA00);
    wait_n(2);
    chk("R2 code 5 as tone", 64'(phase_o), 7);
  endtask

  task automatic t_fsk();
    do_reset();
    f1_word_i = ONE; f2_word_i = 3 * ONE; data_i = 1'b1;
    load(32'h200);
    wait_n(4);
    chk("R3 fsk high", 64'(phase_o), 12);
    data_i = 1'b0;
    wait_n(4);
    chk("R3 fsk low", 64'(phase_o), 16);
  endtask

  task automatic t_bpsk();
    do_reset();
    f1_word_i = ONE; f2_word_i = 9 * ONE;
    phase_off1_i = 16'h0100; phase_off2_i = 16'h8000; data_i = 1'b1;
    load(32'h800);
    wait_n(3);
    chk("R4 bpsk data1", 64'(phase_o), 64'h8003);
    data_i = 1'b0;
    #1;
    chk("R4 bpsk data0", 64'(phase_o), 64'h0103);
    load(32'h0);
    chk("R4 no offset in tone", 64'(phase_o), 4);
  endtask

  task automatic t_chirp();
    int exp_d[9] = '{0, 0, 0, 1, 1, 1, 2, 2, 2};
    do_reset();
    step_word_i = ONE; ramp_rate_i = 20'd2;
    load(32'h600);
    mark();
    foreach (exp_d[i]) step_delta("R5 chirp rate", exp_d[i]);
  endtask

  task automatic t_clr_chirp();
    int exp_d[5] = '{6, 0, 1, 2, 3};
    do_reset();
    step_word_i = ONE;
    load(32'h600);
    wait_n(5);
    load(32'h600 | 32'h8000);
    mark();
    foreach (exp_d[i]) step_delta("R8 one-shot chirp", exp_d[i]);
  endtask

  task automatic t_rfsk();
    int up_d[6] = '{0, 3, 6, 9, 10, 10};
    int dn_d[6] = '{10, 7, 4, 1, 0, 0};
    int cl_d[4] = '{10, 0, 3, 6};
    do_reset();
    f2_word_i = 10 * ONE; step_word_i = 3 * ONE; data_i = 1'b1;
    load(32'h400);
    mark();
    foreach (up_d[i]) step_delta("R6 ramp up clamp", up_d[i]);
    data_i = 1'b0;
    foreach (dn_d[i]) step_delta("R6 ramp down clamp", dn_d[i]);
    data_i = 1'b1;
    wait_n(8);
    load(32'h400 | 32'h8000);
    mark();
    foreach (cl_d[i]) step_delta("R8 one-shot ramped fsk", cl_d[i]);
  endtask

  task automatic t_triangle();
    int tri_d[9] = '{0, 2, 4, 6, 4, 2, 4, 6, 4};
    int chp_d[6] = '{0, 1, 2, 3, 4, 5};
    do_reset();
    f1_word_i = 2 * ONE; f2_word_i = 6 * ONE; step_word_i = 2 * ONE;
    load(32'h400 | 32'h2000);
    mark();
    foreach (tri_d[i]) step_delta("R7 triangle", tri_d[i]);
    do_reset();
    f2_word_i = 2 * ONE; step_word_i = ONE;
    load(32'h600 | 32'h2000);
    mark();
    foreach (chp_d[i]) step_delta("R7 ignored in chirp", chp_d[i]);
  endtask

  task automatic t_clr_all();
    do_reset();
    f1_word_i = ONE;
    load(32'h0);
    wait_n(3);
    load(32'h4000);
    wait_n(1);
    chk("R9 held zero", 64'(phase_o), 0);
    wait_n(3);
    chk("R9 still zero", 64'(phase_o), 0);
    load(32'h0);
    wait_n(3);
    chk("R9 restart", 64'(phase_o), 3);
  endtask

  task automatic t_halt();
    do_reset();
    f1_word_i = ONE;
    load(32'h0);
    wait_n(3);
    load(32'h0800_0000);
    chk("R10 last advance", 64'(phase_o), 4);
    wait_n(5);
    chk("R10 frozen", 64'(phase_o), 4);
    load(32'h0);
    wait_n(3);
    chk("R10 update no release", 64'(phase_o), 4);
    do_reset();
    f1_word_i = ONE;
    load(32'h0);
    wait_n(2);
    chk("R10 reset releases", 64'(phase_o), 2);
  endtask

  task automatic t_amp();
    do_reset();
    amp_mult_i = 12'h123;
    load(32'h20);
    chk("R11 multiplier", 64'(amp_o), 64'h123);
    load(32'h0);
    chk("R11 full scale", 64'(amp_o), 64'hFFF);
    load(32'h40);
    chk("R12 sinc bypass", 64'(sinc_bypass_o), 1);
    do_reset();
    data_i = 1'b1;
    load(32'h30);
    wait_n(5);
    chk("R11 ramp up", 64'(amp_o), 5);
    data_i = 1'b0;
    wait_n(2);
    chk("R11 ramp down", 64'(amp_o), 3);
    data_i = 1'b1;
    wait_n(5000);
    chk("R11 ramp saturate", 64'(amp_o), 64'hFFF);
  endtask

  initial begin
    t_reset();
    t_tone_update();
    t_fsk();
    t_bpsk();
    t_chirp();
    t_clr_chirp();
    t_rfsk();
    t_triangle();
    t_clr_all();
    t_halt();
    t_amp();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule